// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog

This block is a watchdog timer. It counts down from a programmed tick value. A prescaler divides the system clock into ticks, and each tick lowers the count by one. When the count runs out, the block raises an expiry flag and reloads the count from the limit register. It then keeps counting.

If the count runs out a second time while software has still not cleared the expiry flag, the block raises a second-stage flag. That second expiry can also request a system reset. Software services the watchdog through a plain synchronous register port with these registers:

- kick/count
- limit
- control
- two status words
- two byte-wide mailboxes

A write to either mailbox is recorded in the first status word, beside the expiry flag. Both status words are write-one-to-clear. Every flag is also driven out as a level, for an interrupt source outside the block.

The register port is control, not a data stream, so it has no back-pressure. A write takes effect at the clock edge that samples `bus_wr`. Read data appears on `bus_rdata` after the edge that samples `bus_rd`, and it holds until the next read.

Top module: `wdt_two_stage`

## Requirements
- R1: A write of any value to address 0 (kick) copies the limit register (address 1) into the count and restarts the prescaler phase. A read of address 0 then returns that value.
- R2: While running, the count drops by exactly one every DIV clock cycles. The first tick comes DIV cycles after the edge that clears the halt bit.
- R3: A tick that finds the count at 1 sets status-1 bit 0 (expired) and reloads the count from the limit, so the count never reads 0. With the limit at the field maximum (2^CNT_W−1), the count reads 1 after limit−1 ticks with bit 0 still clear. One more tick sets bit 0.
- R4: Status word 1 (address 2) is write-one-to-clear. Writing back the value just read leaves it at zero.
- R5: An expiry that occurs while status-1 bit 0 is already set also sets status-2 (address 3) bit 0 (second expiry). An expiry that occurs after bit 0 was cleared sets only status-1 bit 0.
- R6: With control bit 1 (reset enable) set and `no_reboot` low, a second expiry produces a `rst_req` pulse exactly one cycle wide, in the cycle after that expiry.
- R7: With `no_reboot` high or reset enable clear, a second expiry gives no `rst_req` pulse. It sets status-2 bit 1 (boot flag) beside bit 0. Status word 2 is write-one-to-clear.
- R8: A write to address 5 (mailbox in) sets status-1 bit 1. A write to address 6 (mailbox out) sets status-1 bit 2. Each mailbox keeps the low byte written, and a read returns it.
- R9: Control bit 0 (halt) freezes both the count and the prescaler phase. Clearing it resumes counting.
- R10: `irq_expired`, `irq_din`, `irq_dout` and `irq_second` follow status-1 bits 0, 1, 2 and status-2 bit 0 as levels.
- R11: After reset the count holds RST_COUNT (default 4) and the control word reads 1 (halted, reset disabled). Both status words are zero and `rst_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| no_reboot | input | 1 | Suppresses the reset request on a second expiry |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, registered |
| rst_req | output | 1 | One-cycle system reset request |
| irq_expired | output | 1 | Level of the expiry flag |
| irq_din | output | 1 | Level of the mailbox-in flag |
| irq_dout | output | 1 | Level of the mailbox-out flag |
| irq_second | output | 1 | Level of the second-expiry flag |

## Verification
Take k as the edge that clears the halt bit. Tick j then lands on edge k + j·DIV. A read sampled at edge e reports the state left by edge e−1, so it sees every tick up to and including that edge. The bench therefore pads each read with idle cycles so that it lands just after a known tick. For example, the reload check is sampled one edge after the expiring tick, and the max-limit check sits one edge on either side of the final tick. The `rst_req` pulse is due one edge after the second expiry. A negedge monitor counts its high cycles over a window that closes before the next expiry can fire.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    A_KICK  = 3'd0,
    A_LIMIT = 3'd1,
    A_STAT1 = 3'd2,
    A_STAT2 = 3'd3,
    A_CTRL  = 3'd4,
    A_MBIN  = 3'd5,
    A_MBOUT = 3'd6
  } wdt_addr_e;

  localparam int S1_EXP    = 0;
  localparam int S1_MBIN   = 1;
  localparam int S1_MBOUT  = 2;
  localparam int S1_W      = 3;
  localparam int S2_SECOND = 0;
  localparam int S2_BOOT   = 1;
  localparam int S2_W      = 2;
  localparam int CT_HALT   = 0;
  localparam int CT_RSTEN  = 1;
  localparam int CT_W      = 2;
  localparam int MB_W      = 8;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run && !restart;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (restart) phase <= '0;
        else if (run)     phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end

      assign tick = run && !restart && (phase == LAST);

      AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase)); // R9
      AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0)); // R1
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W     = 10,
  parameter int RST_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST = CNT_W'(RST_COUNT);

  logic at_end;
  assign at_end = (count <= ONE);
  assign expire = tick && !load && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= RST;
    else if (load)  count <= reload_val;
    else if (tick)  count <= at_end ? reload_val : count - ONE;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(reload_val))); // R1
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && count > ONE) |=> (count == $past(count) - ONE)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count)); // R9
  AST_EXPIRY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(reload_val))); // R3
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int DATA_W    = 16,
  parameter int RST_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              no_reboot,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic [CNT_W-1:0]  limit,
  output logic              load,
  output logic              halted,
  output logic              rst_req,
  output logic [S1_W-1:0]   stat1,
  output logic [S2_W-1:0]   stat2
);
  logic [CT_W-1:0] ctrl;
  logic [MB_W-1:0] mb_in, mb_out;
  logic wr_limit, wr_ctrl, wr_s1, wr_s2, wr_mbin, wr_mbout;
  logic second, deliver;
  logic [S1_W-1:0] s1_set, s1_clr;
  logic [S2_W-1:0] s2_set, s2_clr;

  assign load     = bus_wr && (bus_addr == A_KICK);
  assign wr_limit = bus_wr && (bus_addr == A_LIMIT);
  assign wr_s1    = bus_wr && (bus_addr == A_STAT1);
  assign wr_s2    = bus_wr && (bus_addr == A_STAT2);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_mbin  = bus_wr && (bus_addr == A_MBIN);
  assign wr_mbout = bus_wr && (bus_addr == A_MBOUT);

  assign second  = expire && stat1[S1_EXP];
  assign deliver = second && ctrl[CT_RSTEN] && !no_reboot;

  always_comb begin
    s1_set = '0;
    s1_set[S1_EXP]   = expire;
    s1_set[S1_MBIN]  = wr_mbin;
    s1_set[S1_MBOUT] = wr_mbout;
    s2_set = '0;
    s2_set[S2_SECOND] = second;
    s2_set[S2_BOOT]   = second && !deliver;
    s1_clr = wr_s1 ? bus_wdata[S1_W-1:0] : '0;
    s2_clr = wr_s2 ? bus_wdata[S2_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit   <= CNT_W'(RST_COUNT);
      ctrl    <= CT_W'(1);
      mb_in   <= '0;
      mb_out  <= '0;
      stat1   <= '0;
      stat2   <= '0;
      rst_req <= 1'b0;
    end else begin
      if (wr_limit) limit  <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl)  ctrl   <= bus_wdata[CT_W-1:0];
      if (wr_mbin)  mb_in  <= bus_wdata[MB_W-1:0];
      if (wr_mbout) mb_out <= bus_wdata[MB_W-1:0];
      stat1   <= (stat1 & ~s1_clr) | s1_set;
      stat2   <= (stat2 & ~s2_clr) | s2_set;
      rst_req <= deliver;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_KICK:  bus_rdata <= DATA_W'(count);
        A_LIMIT: bus_rdata <= DATA_W'(limit);
        A_STAT1: bus_rdata <= DATA_W'(stat1);
        A_STAT2: bus_rdata <= DATA_W'(stat2);
        A_CTRL:  bus_rdata <= DATA_W'(ctrl);
        A_MBIN:  bus_rdata <= DATA_W'(mb_in);
        A_MBOUT: bus_rdata <= DATA_W'(mb_out);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign halted = ctrl[CT_HALT];

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6
  AST_RST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(no_reboot)); // R7
  AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat2[S2_SECOND]) |-> stat1[S1_EXP]); // R5
  AST_S1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s1 && bus_wdata[S1_EXP] && !expire) |=> !stat1[S1_EXP]); // R4
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int CNT_W     = 10,
  parameter int DATA_W    = 16,
  parameter int RST_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              no_reboot,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              irq_expired,
  output logic              irq_din,
  output logic              irq_dout,
  output logic              irq_second
);
  logic             tick, load, expire, halted;
  logic [CNT_W-1:0] count, limit;
  logic [S1_W-1:0]  stat1;
  logic [S2_W-1:0]  stat2;

  wdt_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!halted), .restart(load), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .RST_COUNT(RST_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .reload_val(limit), .count(count), .expire(expire)
  );

  wdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .RST_COUNT(RST_COUNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .no_reboot(no_reboot),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .expire(expire), .limit(limit), .load(load),
    .halted(halted), .rst_req(rst_req), .stat1(stat1), .stat2(stat2)
  );

  assign irq_expired = stat1[S1_EXP];
  assign irq_din     = stat1[S1_MBIN];
  assign irq_dout    = stat1[S1_MBOUT];
  assign irq_second  = stat2[S2_SECOND];

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> ##1 (count != '0 || $past(limit) == '0 || $past(count) == '0)); // R3
endmodule

// File: tb/test_wdt_two_stage.sv
module test_wdt_two_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic no_reboot = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic rst_req, irq_expired, irq_din, irq_dout, irq_second;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_two_stage i_wdt_two_stage (
    .clk(clk), .rst_n(rst_n), .no_reboot(no_reboot),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
    .irq_expired(irq_expired), .irq_din(irq_din), .irq_dout(irq_dout),
    .irq_second(irq_second)
  );

  always @(negedge clk) if (rst_n && rst_req) pulses++;

  // op: 0 write, 1 read and compare, 2 idle (data = cycles); last field is the requirement number
  localparam int NV = 35;
  localparam logic [40:0] VEC [NV] = '{
    {2'd1, 3'd2, 16'h0000, 16'h0000, 4'd11},  // R11 status 1 clear
    {2'd1, 3'd0, 16'h0000, 16'h0004, 4'd11},  // R11 count at reset
    {2'd1, 3'd4, 16'h0000, 16'h0001, 4'd11},  // R11 halted
    {2'd0, 3'd1, 16'h0005, 16'h0000, 4'd1},
    {2'd0, 3'd0, 16'h0000, 16'h0000, 4'd1},   // R1 kick
    {2'd1, 3'd0, 16'h0000, 16'h0005, 4'd1},   // R1 loaded value
    {2'd2, 3'd0, 16'd10,   16'h0000, 4'd9},
    {2'd1, 3'd0, 16'h0000, 16'h0005, 4'd9},   // R9 no count while halted
    {2'd0, 3'd4, 16'h0000, 16'h0000, 4'd2},   // run, edge k
    {2'd2, 3'd0, 16'd8,    16'h0000, 4'd2},
    {2'd1, 3'd0, 16'h0000, 16'h0003, 4'd2},   // R2 two ticks
    {2'd2, 3'd0, 16'd7,    16'h0000, 4'd3},
    {2'd1, 3'd0, 16'h0000, 16'h0001, 4'd3},   // R3 reaches 1
    {2'd1, 3'd2, 16'h0000, 16'h0000, 4'd3},   // R3 no flag yet
    {2'd2, 3'd0, 16'd2,    16'h0000, 4'd3},
    {2'd1, 3'd2, 16'h0000, 16'h0001, 4'd3},   // R3 expired
    {2'd1, 3'd0, 16'h0000, 16'h0005, 4'd3},   // R3 reloaded
    {2'd0, 3'd2, 16'h0001, 16'h0000, 4'd4},
    {2'd1, 3'd2, 16'h0000, 16'h0000, 4'd4},   // R4 cleared
    {2'd2, 3'd0, 16'd17,   16'h0000, 4'd5},
    {2'd1, 3'd3, 16'h0000, 16'h0000, 4'd5},   // R5 no second after clear
    {2'd1, 3'd2, 16'h0000, 16'h0001, 4'd5},   // R5 first flag again
    {2'd2, 3'd0, 16'd18,   16'h0000, 4'd5},
    {2'd1, 3'd3, 16'h0000, 16'h0003, 4'd5},   // R5 second + boot (R7)
    {2'd0, 3'd3, 16'h0003, 16'h0000, 4'd7},
    {2'd1, 3'd3, 16'h0000, 16'h0000, 4'd7},   // R7 status 2 cleared
    {2'd0, 3'd5, 16'h12A5, 16'h0000, 4'd8},
    {2'd0, 3'd6, 16'h003C, 16'h0000, 4'd8},
    {2'd1, 3'd2, 16'h0000, 16'h0007, 4'd8},   // R8 both mailbox flags
    {2'd1, 3'd5, 16'h0000, 16'h00A5, 4'd8},   // R8 low byte kept
    {2'd0, 3'd2, 16'h0007, 16'h0000, 4'd4},
    {2'd1, 3'd2, 16'h0000, 16'h0000, 4'd4},   // R4 write-back clears
    {2'd0, 3'd4, 16'h0001, 16'h0000, 4'd9},   // halt again
    {2'd2, 3'd0, 16'd20,   16'h0000, 4'd9},
    {2'd1, 3'd0, 16'h0000, 16'h0003, 4'd9}    // R9 frozen at 3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    pulses = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    logic [15:0] v;
    @(negedge clk);
    do_reset();
    check("R11 rst_req", {15'd0, rst_req}, 16'd0);
    check("R11 irq levels", {12'd0, irq_expired, irq_din, irq_dout, irq_second}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][40:39])
        2'd0: wr(VEC[i][38:36], VEC[i][35:20]);
        2'd1: begin
          rd(VEC[i][38:36], v);
          check($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][19:4]);
        end
        default: idle(int'(VEC[i][35:20]));
      endcase
    end

    // R6: reset request pulse on second expiry
    do_reset();
    wr(3'd1, 16'd2); wr(3'd0, 16'd0); wr(3'd4, 16'h0002);
    idle(18);
    check("R6 pulse count", 16'(pulses), 16'd1);
    rd(3'd3, v);
    check("R6 status 2 no boot", v, 16'h0001);
    check("R10 irq_second", {15'd0, irq_second}, 16'd1);

    // R7: no_reboot masks the pulse
    do_reset();
    no_reboot = 1'b1;
    wr(3'd1, 16'd2); wr(3'd0, 16'd0); wr(3'd4, 16'h0002);
    idle(18);
    check("R7 no pulse", 16'(pulses), 16'd0);
    rd(3'd3, v);
    check("R7 boot flag", v, 16'h0003);
    no_reboot = 1'b0;

    // R3: maximum limit
    do_reset();
    wr(3'd1, 16'h03FF); wr(3'd0, 16'd0); wr(3'd4, 16'h0000);
    idle(4088);
    rd(3'd0, v);
    check("R3 max count at 1", v, 16'h0001);
    rd(3'd2, v);
    check("R3 max no flag", v, 16'h0000);
    idle(2);
    rd(3'd2, v);
    check("R3 max flag set", v, 16'h0001);
    check("R10 irq_expired", {15'd0, irq_expired}, 16'd1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end
endmodule